// File: doc/BRIEF.md
# Eight-Bit Arithmetic/Logic Unit with Sticky Flags

This block is the arithmetic core of a small byte-oriented processor. It takes an accumulator byte and an operand byte and, when `opValid` is high, performs one operation chosen by a 2-bit group select and a 3-bit code. The main group holds addition, subtraction, the three bitwise operations and compare. The accumulator group holds the rotates, decimal adjust, complement and the two carry-only operations. The remaining two groups are a single-operand increment and a single-operand decrement. The byte result and the two write strobes come out combinationally in the same cycle. `accWrite` tells the surrounding datapath to load the result into the accumulator. `regWrite` tells it to load the result into the register that supplied the operand.

Five status flags (sign, zero, half-carry, parity, carry) sit in a register inside the block. Each operation loads only the flags it is defined to affect. All other flags, and all flags in cycles without an operation, keep their previous value. A 3-bit condition code is tested against the registered flags at all times, so branch logic can consult the flags left by the last operation that affected them.

Top module: `stickyFlagAlu`

## Requirements
- R1: `opGroup` encodes 0 = main group, 1 = accumulator group, 2 = increment, 3 = decrement. In the main group, code 0 gives acc+operand, 1 gives acc+operand+carry, 2 gives acc-operand, 3 gives acc-operand-carry, 4 gives AND, 5 gives XOR and 6 gives OR, each modulo 256, with `accWrite` high while `opValid` is high.
- R2: For every operation that affects sign, zero and parity, sign becomes result bit 7, zero is set when the result is 0x00, and parity is set when the result has an even number of ones.
- R3: Codes 0 and 1 set carry to the carry out of bit 7 and half-carry to the carry out of bit 3 (low nibbles plus the carry-in).
- R4: Codes 2, 3 and 7 set carry when the unsigned subtrahend (operand, plus carry for code 3) exceeds the accumulator. Half-carry becomes the carry out of bit 3 of acc + ~operand + (1 - borrow-in).
- R5: Compare (code 7) loads all five flags as subtraction does, while `accWrite` stays low.
- R6: AND, OR and XOR clear both carry and half-carry.
- R7: In the accumulator group, code 0 rotates left with bit 7 wrapping to bit 0, code 1 rotates right with bit 0 wrapping to bit 7, code 2 rotates left through carry and code 3 rotates right through carry. Each loads carry with the bit shifted out and changes no other flag.
- R8: Decimal adjust (accumulator group code 4) first adds 0x06 if the low nibble is above 9 or half-carry is set. It then adds 0x60 if the intermediate high nibble is above 9, carry is set, or the first step overflowed the byte. Carry becomes 1 exactly when the second step applies, half-carry becomes 1 when the original low nibble is above 9, and sign, zero and parity follow R2.
- R9: Complement (code 5) writes ~acc and changes no flag. Set-carry (code 6) and complement-carry (code 7) change only carry, keep `accWrite` low and pass the accumulator to `result`.
- R10: Increment and decrement give operand±1 modulo 256 with `regWrite` high and `accWrite` low, load sign, zero, parity and half-carry, and leave carry unchanged. Half-carry is set on increment when the operand low nibble is 0xF, and on decrement when it is nonzero.
- R11: Flag updates appear on `flagsOut` after the clock edge that ends the operation's cycle. With `opValid` low, no flag and no write strobe changes, whatever the other inputs are.
- R12: `condMet` is true for condition code 0 when zero is clear, 1 when zero is set, 2 when carry is set, 3 when carry is clear, 4 when parity is clear, 5 when parity is set, 6 when sign is clear and 7 when sign is set.
- R13: Reset (active low) clears all five flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation runs this cycle |
| opGroup | input | 2 | Operation group select |
| opCode | input | 3 | Operation code within the group |
| accIn | input | 8 | Accumulator value |
| operandIn | input | 8 | Second operand, or the single operand for increment/decrement |
| condCode | input | 3 | Condition code to test |
| result | output | 8 | Operation result |
| accWrite | output | 1 | Load result into the accumulator |
| regWrite | output | 1 | Load result into the operand register |
| flagsOut | output | 5 | Registered flags {sign, zero, half, parity, carry} |
| condMet | output | 1 | Selected condition holds on the registered flags |

## Verification
`result`, `accWrite`, `regWrite` and `condMet` are combinational, so the bench reads them a short delay after driving inputs at the falling edge, in the same cycle as the stimulus. The flag effects of an operation are due one rising edge later, so `flagsOut` is compared just after that edge against a bench model that carries its own flag state forward from operation to operation. Because the model flags evolve continuously, carry-in and half-carry take both values across the sweeps. The decimal-adjust sweep sets them on purpose with a preceding addition. Idle cycles with scrambled inputs confirm that the flags stay unchanged.

// File: rtl/stickyAluPkg.sv
package stickyAluPkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int CODE_W = 3;
  localparam int GRP_W  = 2;
  localparam int FLAG_W = 5;
  localparam logic [NIB_W-1:0] NIB_MAX_DEC = NIB_W'(9);

  typedef enum logic [GRP_W-1:0] {
    GRP_MAIN = 2'd0,
    GRP_ACC  = 2'd1,
    GRP_INC  = 2'd2,
    GRP_DEC  = 2'd3
  } opGroup_e;

  typedef enum logic [CODE_W-1:0] {
    M_ADD = 3'd0, M_ADDC = 3'd1, M_SUB = 3'd2, M_SUBB = 3'd3,
    M_AND = 3'd4, M_XOR  = 3'd5, M_OR  = 3'd6, M_CMP  = 3'd7
  } mainOp_e;

  typedef enum logic [CODE_W-1:0] {
    A_ROTL = 3'd0, A_ROTR = 3'd1, A_ROTLC = 3'd2, A_ROTRC = 3'd3,
    A_DECADJ = 3'd4, A_INV = 3'd5, A_SETC = 3'd6, A_FLIPC = 3'd7
  } accOp_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic half;
    logic parity;
    logic carry;
  } flags_t;

  typedef struct packed {
    logic accWrite;
    logic regWrite;
    logic loadSzp;
    logic loadHalf;
    logic loadCarry;
  } aluCtrl_t;
endpackage

// File: rtl/aluControl.sv
module aluControl
  import stickyAluPkg::*;
(
  input  logic              opValid,
  input  logic [GRP_W-1:0]  opGroup,
  input  logic [CODE_W-1:0] opCode,
  output aluCtrl_t          ctrl
);
  always_comb begin
    ctrl = '0;
    if (opValid) begin
      case (opGroup_e'(opGroup))
        GRP_MAIN: begin
          ctrl.loadSzp   = 1'b1;
          ctrl.loadHalf  = 1'b1;
          ctrl.loadCarry = 1'b1;
          ctrl.accWrite  = (mainOp_e'(opCode) != M_CMP);
        end
        GRP_ACC: begin
          case (accOp_e'(opCode))
            A_ROTL, A_ROTR, A_ROTLC, A_ROTRC: begin
              ctrl.accWrite  = 1'b1;
              ctrl.loadCarry = 1'b1;
            end
            A_DECADJ: begin
              ctrl.accWrite  = 1'b1;
              ctrl.loadSzp   = 1'b1;
              ctrl.loadHalf  = 1'b1;
              ctrl.loadCarry = 1'b1;
            end
            A_INV:           ctrl.accWrite  = 1'b1;
            A_SETC, A_FLIPC: ctrl.loadCarry = 1'b1;
            default:         ctrl = '0;
          endcase
        end
        GRP_INC, GRP_DEC: begin
          ctrl.regWrite = 1'b1;
          ctrl.loadSzp  = 1'b1;
          ctrl.loadHalf = 1'b1;
        end
        default: ctrl = '0;
      endcase
    end
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import stickyAluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  aluCtrl_t          ctrl,
  input  logic [GRP_W-1:0]  opGroup,
  input  logic [CODE_W-1:0] opCode,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  output logic [DATA_W-1:0] result,
  output flags_t            flagsQ
);
  // adder shared by add, add-with-carry, subtract, subtract-with-borrow, compare
  logic                isSub;
  logic                useCarry;
  logic                adderIn;
  logic [DATA_W-1:0]   addendB;
  logic [DATA_W:0]     addSum;
  logic [NIB_W:0]      addLow;
  logic                arithCarry;

  always_comb begin
    isSub    = (opCode == M_SUB) || (opCode == M_SUBB) || (opCode == M_CMP);
    useCarry = (opCode == M_ADDC) || (opCode == M_SUBB);
    adderIn  = isSub ? ~(useCarry & flagsQ.carry) : (useCarry & flagsQ.carry);
    addendB  = isSub ? ~operandIn : operandIn;
    addSum   = {1'b0, accIn} + {1'b0, addendB} + (DATA_W+1)'(adderIn);
    addLow   = {1'b0, accIn[NIB_W-1:0]} + {1'b0, addendB[NIB_W-1:0]} + (NIB_W+1)'(adderIn);
    arithCarry = isSub ? ~addSum[DATA_W] : addSum[DATA_W];
  end

  // decimal adjust, two correction steps
  logic              lowFix;
  logic              highFix;
  logic [DATA_W:0]   decMid;
  logic [DATA_W-1:0] decRes;

  always_comb begin
    lowFix  = (accIn[NIB_W-1:0] > NIB_MAX_DEC) || flagsQ.half;
    decMid  = {1'b0, accIn} + (lowFix ? (DATA_W+1)'(9'h006) : '0);
    highFix = (decMid[DATA_W-1:NIB_W] > NIB_MAX_DEC) || flagsQ.carry || decMid[DATA_W];
    decRes  = decMid[DATA_W-1:0] + (highFix ? DATA_W'(8'h60) : '0);
  end

  // result and candidate half/carry per operation
  logic nextHalf;
  logic nextCarry;

  always_comb begin
    result    = accIn;
    nextHalf  = flagsQ.half;
    nextCarry = flagsQ.carry;
    case (opGroup_e'(opGroup))
      GRP_MAIN: begin
        case (mainOp_e'(opCode))
          M_AND: begin result = accIn & operandIn; nextHalf = 1'b0; nextCarry = 1'b0; end
          M_XOR: begin result = accIn ^ operandIn; nextHalf = 1'b0; nextCarry = 1'b0; end
          M_OR:  begin result = accIn | operandIn; nextHalf = 1'b0; nextCarry = 1'b0; end
          default: begin
            result    = addSum[DATA_W-1:0];
            nextHalf  = addLow[NIB_W];
            nextCarry = arithCarry;
          end
        endcase
      end
      GRP_ACC: begin
        case (accOp_e'(opCode))
          A_ROTL:  begin result = {accIn[DATA_W-2:0], accIn[DATA_W-1]}; nextCarry = accIn[DATA_W-1]; end
          A_ROTR:  begin result = {accIn[0], accIn[DATA_W-1:1]};        nextCarry = accIn[0]; end
          A_ROTLC: begin result = {accIn[DATA_W-2:0], flagsQ.carry};    nextCarry = accIn[DATA_W-1]; end
          A_ROTRC: begin result = {flagsQ.carry, accIn[DATA_W-1:1]};    nextCarry = accIn[0]; end
          A_DECADJ: begin
            result    = decRes;
            nextHalf  = accIn[NIB_W-1:0] > NIB_MAX_DEC;
            nextCarry = highFix;
          end
          A_INV:   result = ~accIn;
          A_SETC:  nextCarry = 1'b1;
          A_FLIPC: nextCarry = ~flagsQ.carry;
          default: result = accIn;
        endcase
      end
      GRP_INC: begin
        result   = operandIn + DATA_W'(1);
        nextHalf = &operandIn[NIB_W-1:0];
      end
      GRP_DEC: begin
        result   = operandIn - DATA_W'(1);
        nextHalf = |operandIn[NIB_W-1:0];
      end
      default: result = accIn;
    endcase
  end

  // sticky flag register: each flag loads only under its strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
    end else begin
      if (ctrl.loadSzp) begin
        flagsQ.sign   <= result[DATA_W-1];
        flagsQ.zero   <= (result == '0);
        flagsQ.parity <= ~^result;
      end
      if (ctrl.loadHalf)  flagsQ.half  <= nextHalf;
      if (ctrl.loadCarry) flagsQ.carry <= nextCarry;
    end
  end
endmodule

// File: rtl/condCheck.sv
module condCheck
  import stickyAluPkg::*;
(
  input  flags_t            flags,
  input  logic [CODE_W-1:0] condCode,
  output logic              condMet
);
  logic [(1<<CODE_W)-1:0] condVec;

  always_comb begin
    // pairs: even code tests a flag clear, odd code tests it set,
    // except carry where the set test comes first
    condVec[0] = ~flags.zero;
    condVec[1] =  flags.zero;
    condVec[2] =  flags.carry;
    condVec[3] = ~flags.carry;
    condVec[4] = ~flags.parity;
    condVec[5] =  flags.parity;
    condVec[6] = ~flags.sign;
    condVec[7] =  flags.sign;
    condMet    = condVec[condCode];
  end
endmodule

// File: rtl/stickyFlagAlu.sv
module stickyFlagAlu
  import stickyAluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [GRP_W-1:0]  opGroup,
  input  logic [CODE_W-1:0] opCode,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  input  logic [CODE_W-1:0] condCode,
  output logic [DATA_W-1:0] result,
  output logic              accWrite,
  output logic              regWrite,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              condMet
);
  aluCtrl_t ctrl;
  flags_t   flagsQ;

  aluControl uCtrl (
    .opValid (opValid),
    .opGroup (opGroup),
    .opCode  (opCode),
    .ctrl    (ctrl)
  );

  aluDatapath uData (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .opGroup   (opGroup),
    .opCode    (opCode),
    .accIn     (accIn),
    .operandIn (operandIn),
    .result    (result),
    .flagsQ    (flagsQ)
  );

  condCheck uCond (
    .flags    (flagsQ),
    .condCode (condCode),
    .condMet  (condMet)
  );

  assign accWrite = ctrl.accWrite;
  assign regWrite = ctrl.regWrite;
  assign flagsOut = flagsQ;
endmodule

// File: rtl/stickyFlagAluChecker.sv
module stickyFlagAluChecker
  import stickyAluPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [GRP_W-1:0]  opGroup,
  input logic [CODE_W-1:0] opCode,
  input logic [DATA_W-1:0] result,
  input logic              accWrite,
  input logic              regWrite,
  input logic [FLAG_W-1:0] flagsOut
);
  logic isMain, isAcc, isStep;
  assign isMain = opValid && (opGroup == 2'd0);
  assign isAcc  = opValid && (opGroup == 2'd1);
  assign isStep = opValid && (opGroup[1] == 1'b1);

  AST_IDLE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(flagsOut)); // R11
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> (!accWrite && !regWrite)); // R11
  AST_CMP_NO_ACC: assert property (@(posedge clk) disable iff (!rstN)
    (isMain && opCode == 3'd7) |-> !accWrite); // R5
  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    isMain |=> (flagsOut[3] == ($past(result) == '0))); // R2
  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (isMain && opCode >= 3'd4 && opCode <= 3'd6) |=> (flagsOut[0] == 1'b0 && flagsOut[2] == 1'b0)); // R6
  AST_ROT_ONLY_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (isAcc && opCode <= 3'd3) |=> (flagsOut[4:1] == $past(flagsOut[4:1]))); // R7
  AST_INV_NO_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (isAcc && opCode == 3'd5) |=> $stable(flagsOut)); // R9
  AST_SETC_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (isAcc && opCode == 3'd6) |=> (flagsOut[0] == 1'b1)); // R9
  AST_STEP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    isStep |=> (flagsOut[0] == $past(flagsOut[0]))); // R10
  AST_STEP_WRITES_REG: assert property (@(posedge clk) disable iff (!rstN)
    isStep |-> (regWrite && !accWrite)); // R10
endmodule

bind stickyFlagAlu stickyFlagAluChecker uChecker (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opGroup   (opGroup),
  .opCode    (opCode),
  .result    (result),
  .accWrite  (accWrite),
  .regWrite  (regWrite),
  .flagsOut  (flagsOut)
);

// File: tb/stickyFlagAlu_test.sv
module stickyFlagAlu_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [1:0] opGroup = '0;
  logic [2:0] opCode = '0;
  logic [7:0] accIn = '0;
  logic [7:0] operandIn = '0;
  logic [2:0] condCode = '0;
  logic [7:0] result;
  logic       accWrite;
  logic       regWrite;
  logic [4:0] flagsOut;
  logic       condMet;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [4:0] mFlags = '0; // {sign, zero, half, parity, carry}

  stickyFlagAlu uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opGroup(opGroup), .opCode(opCode),
    .accIn(accIn), .operandIn(operandIn), .condCode(condCode), .result(result),
    .accWrite(accWrite), .regWrite(regWrite), .flagsOut(flagsOut), .condMet(condMet)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h (grp %0d code %0d acc %0h opd %0h)",
               tag, got, exp, opGroup, opCode, accIn, operandIn);
    end
  endtask

  function automatic bit evenOnes(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2) == 0;
  endfunction

  function automatic bit condModel(input int cc, input logic [4:0] f);
    case (cc)
      0: return !f[3];
      1: return f[3];
      2: return f[0];
      3: return !f[0];
      4: return !f[1];
      5: return f[1];
      6: return !f[4];
      default: return f[4];
    endcase
  endfunction

  function automatic void model(input int grp, input int code, input int a, input int b,
                                input logic [4:0] f, output int res, output bit aw,
                                output bit rw, output logic [4:0] nf);
    bit c, h, szp, lowFix, highFix;
    int t, ci;
    c = f[0]; h = f[2]; szp = 0; nf = f; aw = 0; rw = 0; res = a;
    case (grp)
      0: begin
        szp = 1; aw = (code != 7);
        case (code)
          0, 1: begin
            ci = (code == 1) ? int'(c) : 0;
            t = a + b + ci; res = t & 255;
            nf[0] = (t > 255);
            nf[2] = (((a & 15) + (b & 15) + ci) > 15);
          end
          2, 3, 7: begin
            ci = (code == 3) ? int'(c) : 0;
            t = a - b - ci; res = t & 255;
            nf[0] = (t < 0);
            nf[2] = (((a & 15) + ((~b) & 15) + (1 - ci)) > 15);
          end
          4: res = a & b;
          5: res = a ^ b;
          default: res = a | b;
        endcase
        if (code >= 4 && code <= 6) begin nf[0] = 0; nf[2] = 0; end
      end
      1: begin
        aw = (code <= 5);
        case (code)
          0: begin res = ((a << 1) | (a >> 7)) & 255; nf[0] = (a >> 7) & 1; end
          1: begin res = (a >> 1) | ((a & 1) << 7);   nf[0] = a & 1; end
          2: begin res = ((a << 1) & 255) | int'(c);  nf[0] = (a >> 7) & 1; end
          3: begin res = (a >> 1) | (int'(c) << 7);   nf[0] = a & 1; end
          4: begin
            lowFix = ((a & 15) > 9) || h;
            t = a + (lowFix ? 6 : 0);
            highFix = (((t >> 4) & 15) > 9) || c || (t > 255);
            res = ((t & 255) + (highFix ? 96 : 0)) & 255;
            nf[0] = highFix; nf[2] = ((a & 15) > 9); szp = 1;
          end
          5: res = (~a) & 255;
          6: nf[0] = 1;
          default: nf[0] = !c;
        endcase
      end
      2: begin res = (b + 1) & 255;   nf[2] = ((b & 15) == 15); rw = 1; szp = 1; end
      default: begin res = (b + 255) & 255; nf[2] = ((b & 15) != 0); rw = 1; szp = 1; end
    endcase
    if (szp) begin
      nf[4] = (res >> 7) & 1;
      nf[3] = (res == 0);
      nf[1] = evenOnes(res);
    end
  endfunction

  function automatic string flagTag(input int grp, input int code);
    if (grp == 0) begin
      if (code <= 1) return "R3";
      if (code == 7) return "R5";
      if (code >= 4) return "R6";
      return "R4";
    end
    if (grp == 1) begin
      if (code <= 3) return "R7";
      if (code == 4) return "R8";
      return "R9";
    end
    return "R10";
  endfunction

  task automatic doOp(input int grp, input int code, input int a, input int b, input int cc);
    int res;
    bit aw, rw;
    logic [4:0] nf;
    string rTag;
    @(negedge clk);
    opValid = 1'b1; opGroup = 2'(grp); opCode = 3'(code);
    accIn = 8'(a); operandIn = 8'(b); condCode = 3'(cc);
    #1;
    model(grp, code, a, b, mFlags, res, aw, rw, nf);
    rTag = (grp == 0 && code != 7) ? "R1" : flagTag(grp, code);
    if (grp == 1 && code == 4) rTag = "R8";
    check({rTag, " result"}, int'(result), res);
    check({rTag, " accWrite"}, int'(accWrite), int'(aw));
    check({rTag, " regWrite"}, int'(regWrite), int'(rw));
    check("R12 condMet", int'(condMet), int'(condModel(cc, mFlags)));
    @(posedge clk);
    #1;
    mFlags = nf;
    check({flagTag(grp, code), " flags"}, int'(flagsOut), int'(mFlags));
    if (grp == 0) check("R2 sign/zero/parity", int'({flagsOut[4:3], flagsOut[1]}),
                        int'({mFlags[4:3], mFlags[1]}));
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      opValid = 1'b0; opGroup = 2'(i); opCode = 3'(i * 3);
      accIn = 8'(i * 37); operandIn = 8'(i * 91);
      #1;
      check("R11 idle accWrite", int'(accWrite), 0);
      check("R11 idle regWrite", int'(regWrite), 0);
      @(posedge clk);
      #1;
      check("R11 idle flags", int'(flagsOut), int'(mFlags));
    end
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R13 reset flags", int'(flagsOut), 0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R13 flags after release", int'(flagsOut), 0);

    // directed boundaries
    doOp(0, 0, 8'hFF, 8'h01, 1);   // wrap to zero, carry and half
    doOp(0, 1, 8'h00, 8'h00, 2);   // add with carry-in
    doOp(0, 2, 8'h00, 8'h01, 3);   // borrow
    doOp(0, 3, 8'h05, 8'h04, 4);   // with borrow-in -> zero
    doOp(0, 7, 8'h10, 8'h20, 7);   // compare
    doOp(0, 4, 8'hF0, 8'h0F, 1);   // and -> zero, carry cleared
    idleCycles(20);

    // main group sweep
    for (int a = 0; a < 256; a += 5)
      for (int b = 0; b < 256; b += 7)
        for (int code = 0; code < 8; code++)
          doOp(0, code, a, b, (a + b + code) % 8);

    // accumulator group sweep (carry evolves through the sequence)
    for (int a = 0; a < 256; a++)
      for (int code = 0; code < 8; code++)
        if (code != 4) doOp(1, code, a, 8'h5A, code);

    // decimal adjust with all four half/carry settings
    for (int a = 0; a < 256; a++) begin
      doOp(0, 0, 8'h00, 8'h00, 0); doOp(1, 4, a, 0, 1);
      doOp(0, 0, 8'h08, 8'h08, 2); doOp(1, 4, a, 0, 3);
      doOp(0, 0, 8'h80, 8'h80, 4); doOp(1, 4, a, 0, 5);
      doOp(0, 0, 8'h88, 8'h88, 6); doOp(1, 4, a, 0, 7);
    end

    // increment / decrement with both carry values
    for (int b = 0; b < 256; b++) begin
      doOp(1, 6 + (b % 2), 0, 0, 2);
      doOp(2, 0, 8'h33, b, b % 8);
      doOp(3, 0, 8'h33, b, (b + 3) % 8);
    end
    idleCycles(20);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule